// File: doc/BRIEF.md
# Byte-Wide Memory with BCD Calendar Clock

This block is a static byte memory whose eight highest locations double as a calendar clock. A prescaler divides the system clock down to a one-second tick. The tick advances a chain of BCD counters that hold seconds, minutes, hours, weekday, day of month, month, two-digit year and a century toggle. One cycle after each tick, the counter values are copied into the clock locations. The host reaches every location, clock bytes included, with the same chip-select, write-enable and output-enable cycle used for ordinary memory.

Two bits in the control byte govern how the host and the counters share the clock bytes. The freeze bit suspends the refresh so that a multi-byte read sees one consistent instant, and counting continues underneath. The set bit also suspends the refresh so the host can write a new time. When the host clears the set bit, the counters take the written bytes and the second restarts. A power-fail input shuts the host out completely.

Top module: `bcd_time_sram`

## Requirements
- R1: The memory holds 2**ADDR_W bytes (8192 when ADDR_W is 13). A write runs while cs_n and wen_n are both low and is committed with the last address and data seen while both were low, on the first clock edge where either one is high. Read data appears on rdata one clock after the address is presented.
- R2: rdata_oe rises one clock after a cycle with cs_n low, wen_n high and oen_n low, and is low otherwise. rdata_oe low stands for a released, high-impedance bus.
- R3: While pwr_fail is high, the block ignores cs_n: no write is committed, and rdata_oe is low from the next clock on.
- R4: The clock bytes sit at offsets 0 to 7 above base 2**ADDR_W-8. Offset 0 is control: bit 7 is set mode, bit 6 is freeze, bits 5:0 are a stored calibration value. Offsets 1, 2 and 3 are seconds, minutes and hours. Offset 4 is the weekday byte: bits 2:0 hold 1 to 7 and bit 4 holds the century toggle. Offsets 5, 6 and 7 are day of month, month and year. Every field except the century bit is BCD, and hours run 00 to 23.
- R5: The seconds advance once every TICKS_PER_SEC clocks. Seconds wrap from 59 to 00 and carry into minutes. Minutes wrap from 59 to 00 and carry into hours.
- R6: Hours wrap from 23 to 00. That wrap advances the weekday (7 goes to 1) and the day of month.
- R7: April, June, September and November end after day 30. The other months except February end after day 31.
- R8: February ends after day 29 when the BCD year is a multiple of four, and after day 28 otherwise.
- R9: December 31 rolls over to January 1, which advances the year. Year 99 goes to 00 and inverts the century bit.
- R10: While the freeze bit is set, the clock bytes keep their values and the counters keep running. Once the bit is cleared, the next tick writes the true current time into the bytes.
- R11: While the set bit is set, the counters never overwrite the clock bytes. A host write that clears the bit loads offsets 1 to 7 into the counters and restarts the prescaler, so the next tick follows TICKS_PER_SEC clocks later.
- R12: The calibration field in the control byte reads back exactly as it was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_fail | input | 1 | High locks the host out of the block |
| cs_n | input | 1 | Chip select, active low |
| wen_n | input | 1 | Write enable, active low |
| oen_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, registered |
| rdata_oe | output | 1 | High when the block drives rdata |

## Verification
Read data and rdata_oe are due one clock after the address and strobes, so the bench drives on falling edges and samples at the next falling edge. A write is committed on the rising edge after the strobes are released. A load takes effect on that same edge, and the bench takes that edge as time zero for the seconds count. The first tick then updates the counters TICKS_PER_SEC edges later, and the clock bytes follow one edge after that. The bench therefore reads the clock bytes in the middle of the second it expects, well away from either edge, and compares them with the time its own integer calendar reaches after the same number of seconds.

// File: rtl/tk_pkg.sv
package tk_pkg;

  // Clock byte offsets above the clock base
  localparam logic [2:0] OFS_CTRL = 3'd0;
  localparam logic [2:0] OFS_SEC  = 3'd1;
  localparam logic [2:0] OFS_MIN  = 3'd2;
  localparam logic [2:0] OFS_HR   = 3'd3;
  localparam logic [2:0] OFS_WDAY = 3'd4;
  localparam logic [2:0] OFS_MDAY = 3'd5;
  localparam logic [2:0] OFS_MON  = 3'd6;
  localparam logic [2:0] OFS_YR   = 3'd7;

  localparam int CTRL_SET_BIT    = 7;
  localparam int CTRL_FREEZE_BIT = 6;
  localparam int WDAY_CENT_BIT   = 4;

  typedef struct packed {
    logic       cent;
    logic [2:0] wday;
    logic [7:0] yr;
    logic [7:0] mon;
    logic [7:0] mday;
    logic [7:0] hrs;
    logic [7:0] mins;
    logic [7:0] secs;
  } tk_time_t;

  localparam tk_time_t TK_EPOCH = '{cent: 1'b0, wday: 3'd1, yr: 8'h00,
                                    mon: 8'h01, mday: 8'h01, hrs: 8'h00,
                                    mins: 8'h00, secs: 8'h00};

  function automatic logic [7:0] bcd_step(input logic [7:0] v);
    if (v[3:0] >= 4'h9) return {v[7:4] + 4'h1, 4'h0};
    else                return {v[7:4], v[3:0] + 4'h1};
  endfunction

endpackage

// File: rtl/tk_prescaler.sv
module tk_prescaler #(
  parameter int TICKS_PER_SEC = 32768
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  output logic tick
);
  localparam int CW = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS_PER_SEC - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || restart)   cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                  cnt <= cnt + 1'b1;
  end

  assign tick = (cnt == LAST) && !restart;

  generate
    if (TICKS_PER_SEC > 1) begin : g_gap
      // R5
      tick_gap_chk: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);
    end
  endgenerate

endmodule

// File: rtl/tk_host_port.sv
module tk_host_port #(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pwr_fail,
  input  logic              cs_n,
  input  logic              wen_n,
  input  logic              oen_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic              wr_commit,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              rd_oe
);
  logic wr_act, wr_act_q;

  assign wr_act = !pwr_fail && !cs_n && !wen_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_act_q <= 1'b0;
      rd_oe    <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else begin
      wr_act_q <= wr_act;
      rd_oe    <= !pwr_fail && !cs_n && wen_n && !oen_n;
      if (wr_act) begin
        wr_addr <= addr;
        wr_data <= wdata;
      end
    end
  end

  assign wr_commit = wr_act_q && !wr_act && !pwr_fail;

  // R3
  pfail_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    pwr_fail |=> !rd_oe);

  // R2
  oe_needs_read_chk: assert property (@(posedge clk) disable iff (rst)
    (cs_n || oen_n) |=> !rd_oe);

endmodule

// File: rtl/tk_calendar.sv
module tk_calendar
  import tk_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     tick,
  input  logic     load,
  input  tk_time_t load_val,
  output tk_time_t now
);
  logic       leap;
  logic [7:0] last_day;
  logic       c_sec, c_min, c_hr, c_day, c_mon, c_yr;

  always_comb begin
    // a BCD year is a multiple of four when the tens digit is even and the
    // ones digit is 0/4/8, or the tens digit is odd and the ones digit is 2/6
    if (now.yr[4]) leap = (now.yr[3:0] == 4'h2) || (now.yr[3:0] == 4'h6);
    else           leap = (now.yr[3:0] == 4'h0) || (now.yr[3:0] == 4'h4) ||
                          (now.yr[3:0] == 4'h8);
    case (now.mon)
      8'h02:                      last_day = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: last_day = 8'h30;
      default:                    last_day = 8'h31;
    endcase
  end

  assign c_sec = (now.secs == 8'h59);
  assign c_min = c_sec && (now.mins == 8'h59);
  assign c_hr  = c_min && (now.hrs == 8'h23);
  assign c_day = c_hr  && (now.mday >= last_day);
  assign c_mon = c_day && (now.mon >= 8'h12);
  assign c_yr  = c_mon && (now.yr == 8'h99);

  always_ff @(posedge clk) begin
    if (rst) begin
      now <= TK_EPOCH;
    end else if (load) begin
      now <= load_val;
    end else if (tick) begin
      now.secs <= c_sec ? 8'h00 : bcd_step(now.secs);
      if (c_sec) now.mins <= c_min ? 8'h00 : bcd_step(now.mins);
      if (c_min) now.hrs  <= c_hr ? 8'h00 : bcd_step(now.hrs);
      if (c_hr) begin
        now.wday <= (now.wday >= 3'd7) ? 3'd1 : now.wday + 3'd1;
        now.mday <= c_day ? 8'h01 : bcd_step(now.mday);
      end
      if (c_day) now.mon <= c_mon ? 8'h01 : bcd_step(now.mon);
      if (c_mon) now.yr  <= c_yr ? 8'h00 : bcd_step(now.yr);
      if (c_yr)  now.cent <= !now.cent;
    end
  end

  // R5
  sec_range_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && !load && c_sec) |=> (now.secs == 8'h00));

  // R6
  hr_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && !load && c_hr) |=> (now.hrs == 8'h00 && now.mins == 8'h00));

  // R8
  mday_limit_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && !load && c_day) |=> (now.mday == 8'h01));

  // R9
  cent_flip_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && !load && c_yr) |=> (now.cent != $past(now.cent)));

endmodule

// File: rtl/bcd_time_sram.sv
module bcd_time_sram
  import tk_pkg::*;
#(
  parameter int ADDR_W        = 11,
  parameter int TICKS_PER_SEC = 32768
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pwr_fail,
  input  logic              cs_n,
  input  logic              wen_n,
  input  logic              oen_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic              rdata_oe
);
  localparam int DEPTH    = 1 << ADDR_W;
  localparam int CLK_REGS = 8;

  logic              wr_commit;
  logic [ADDR_W-1:0] wr_addr;
  logic [7:0]        wr_data;
  logic              tick, tick_q, load, copy_en, host_clk;
  tk_time_t          now, load_val;

  logic [7:0] ram [DEPTH];
  logic [7:0] ram_q;
  logic [7:0] cb [CLK_REGS];
  logic [7:0] cb_q;
  logic       sel_clk_q;

  tk_host_port #(.ADDR_W(ADDR_W)) u_port (
    .clk(clk), .rst(rst), .pwr_fail(pwr_fail), .cs_n(cs_n), .wen_n(wen_n),
    .oen_n(oen_n), .addr(addr), .wdata(wdata), .wr_commit(wr_commit),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_oe(rdata_oe)
  );

  tk_prescaler #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_div (
    .clk(clk), .rst(rst), .restart(load), .tick(tick)
  );

  tk_calendar u_cal (
    .clk(clk), .rst(rst), .tick(tick), .load(load), .load_val(load_val),
    .now(now)
  );

  assign host_clk = wr_commit && (&wr_addr[ADDR_W-1:3]);
  assign load     = host_clk && (wr_addr[2:0] == OFS_CTRL) &&
                    cb[OFS_CTRL][CTRL_SET_BIT] && !wr_data[CTRL_SET_BIT];
  assign copy_en  = tick_q && !cb[OFS_CTRL][CTRL_SET_BIT] &&
                    !cb[OFS_CTRL][CTRL_FREEZE_BIT];

  always_comb begin
    load_val.secs = cb[OFS_SEC];
    load_val.mins = cb[OFS_MIN];
    load_val.hrs  = cb[OFS_HR];
    load_val.wday = cb[OFS_WDAY][2:0];
    load_val.cent = cb[OFS_WDAY][WDAY_CENT_BIT];
    load_val.mday = cb[OFS_MDAY];
    load_val.mon  = cb[OFS_MON];
    load_val.yr   = cb[OFS_YR];
  end

  function automatic logic [7:0] field_byte(input tk_time_t t,
                                            input logic [2:0] ofs);
    case (ofs)
      OFS_SEC:  return t.secs;
      OFS_MIN:  return t.mins;
      OFS_HR:   return t.hrs;
      OFS_WDAY: return {3'b000, t.cent, 1'b0, t.wday};
      OFS_MDAY: return t.mday;
      OFS_MON:  return t.mon;
      OFS_YR:   return t.yr;
      default:  return 8'h00;
    endcase
  endfunction

  // general storage: synchronous read port, one write port
  always_ff @(posedge clk) begin
    ram_q <= ram[addr];
    if (wr_commit && !host_clk) ram[wr_addr] <= wr_data;
  end

  // clock byte file: host write wins over the once-per-second copy
  always_ff @(posedge clk) begin
    if (rst) begin
      tick_q <= 1'b0;
      for (int i = 0; i < CLK_REGS; i++) cb[i] <= 8'h00;
    end else begin
      tick_q <= tick;
      for (int i = 0; i < CLK_REGS; i++) begin
        if (host_clk && (wr_addr[2:0] == 3'(i)))
          cb[i] <= wr_data;
        else if (copy_en && (i != 0))
          cb[i] <= field_byte(now, 3'(i));
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cb_q      <= 8'h00;
      sel_clk_q <= 1'b0;
    end else begin
      cb_q      <= cb[addr[2:0]];
      sel_clk_q <= &addr[ADDR_W-1:3];
    end
  end

  assign rdata = sel_clk_q ? cb_q : ram_q;

  // R10
  freeze_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cb[OFS_CTRL][CTRL_FREEZE_BIT] && !host_clk) |=>
      ($stable(cb[OFS_SEC]) && $stable(cb[OFS_MIN])));

  // R11
  set_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cb[OFS_CTRL][CTRL_SET_BIT] && !host_clk) |=>
      ($stable(cb[OFS_SEC]) && $stable(cb[OFS_YR])));

  // R3
  pfail_no_store_chk: assert property (@(posedge clk) disable iff (rst)
    pwr_fail |-> !wr_commit);

endmodule

// File: tb/sim_bcd_time_sram.sv
`timescale 1ns/1ps
module sim_bcd_time_sram;
  localparam int AW  = 11;
  localparam int TPS = 64;
  localparam logic [AW-1:0] CB = AW'((1 << AW) - 8);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pwr_fail = 1'b0, cs_n = 1'b1, wen_n = 1'b1, oen_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic rdata_oe;

  int vecs = 0, errs = 0, cyc = 0, p0 = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  bcd_time_sram #(.ADDR_W(AW), .TICKS_PER_SEC(TPS)) u0 (
    .clk(clk), .rst(rst), .pwr_fail(pwr_fail), .cs_n(cs_n), .wen_n(wen_n),
    .oen_n(oen_n), .addr(addr), .wdata(wdata), .rdata(rdata),
    .rdata_oe(rdata_oe)
  );

  typedef struct { int s; int mi; int h; int dw; int d; int mo; int y; int c; } cal_t;

  function automatic logic [7:0] bcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic int mdays(input int mo, input int y);
    if (mo == 2) return (y % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  function automatic cal_t one_sec(input cal_t t);
    cal_t n = t;
    n.s++;
    if (n.s == 60) begin
      n.s = 0; n.mi++;
      if (n.mi == 60) begin
        n.mi = 0; n.h++;
        if (n.h == 24) begin
          n.h = 0;
          n.dw = (n.dw == 7) ? 1 : n.dw + 1;
          n.d++;
          if (n.d > mdays(n.mo, n.y)) begin
            n.d = 1; n.mo++;
            if (n.mo == 13) begin
              n.mo = 1; n.y++;
              if (n.y == 100) begin n.y = 0; n.c = 1 - n.c; end
            end
          end
        end
      end
    end
    return n;
  endfunction

  function automatic logic [7:0] day_byte(input cal_t t);
    return {3'b000, t.c[0], 1'b0, t.dw[2:0]};
  endfunction

  function automatic logic [55:0] pack_t(input cal_t t);
    return {bcd(t.y), bcd(t.mo), bcd(t.d), day_byte(t), bcd(t.h),
            bcd(t.mi), bcd(t.s)};
  endfunction

  task automatic chk(input string req, input logic [63:0] got,
                     input logic [63:0] exp);
    vecs++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic host_wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; cs_n = 1'b0; wen_n = 1'b0;
    @(negedge clk);
    cs_n = 1'b1; wen_n = 1'b1;
    p0 = cyc + 1;
    @(negedge clk);
  endtask

  task automatic host_rd(input logic [AW-1:0] a, output logic [7:0] d,
                         output logic oe);
    @(negedge clk);
    addr = a; cs_n = 1'b0; wen_n = 1'b1; oen_n = 1'b0;
    @(negedge clk);
    d = rdata; oe = rdata_oe;
    cs_n = 1'b1; oen_n = 1'b1;
  endtask

  task automatic wait_until(input int m);
    while (cyc - p0 < m) @(negedge clk);
  endtask

  task automatic set_time(input cal_t t);
    host_wr(CB + 0, 8'h80);
    host_wr(CB + 1, bcd(t.s));
    host_wr(CB + 2, bcd(t.mi));
    host_wr(CB + 3, bcd(t.h));
    host_wr(CB + 4, day_byte(t));
    host_wr(CB + 5, bcd(t.d));
    host_wr(CB + 6, bcd(t.mo));
    host_wr(CB + 7, bcd(t.y));
    host_wr(CB + 0, 8'h00);
  endtask

  task automatic read_time(output logic [55:0] v);
    logic [7:0] b;
    logic oe;
    v = '0;
    for (int i = 1; i <= 7; i++) begin
      host_rd(CB + AW'(i), b, oe);
      v[(i-1)*8 +: 8] = b;
    end
  endtask

  task automatic expect_after(input string req, input cal_t t0, input int k);
    cal_t e = t0;
    logic [55:0] got;
    for (int i = 0; i < k; i++) e = one_sec(e);
    wait_until(k * TPS + TPS / 2);
    read_time(got);
    chk(req, 64'(got), 64'(pack_t(e)));
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset;
    logic [7:0] d; logic oe;
    chk("R2 idle oe", 64'(rdata_oe), 64'd0);
    host_rd(CB + 0, d, oe);
    chk("R4 ctrl at reset", 64'(d), 64'h00);
    chk("R2 read oe", 64'(oe), 64'd1);
  endtask

  task automatic t_ram;
    logic [7:0] d; logic oe;
    host_wr(11'h000, 8'hA5);
    host_wr(11'h3C1, 8'h5A);
    host_wr(CB - 1, 8'hC3);
    host_rd(11'h000, d, oe); chk("R1 low byte", 64'(d), 64'hA5);
    host_rd(11'h3C1, d, oe); chk("R1 mid byte", 64'(d), 64'h5A);
    host_rd(CB - 1, d, oe);  chk("R1 byte below clock", 64'(d), 64'hC3);
    // output enable held high: bus released
    @(negedge clk); addr = 11'h000; cs_n = 1'b0; wen_n = 1'b1; oen_n = 1'b1;
    @(negedge clk); chk("R2 oen high", 64'(rdata_oe), 64'd0);
    cs_n = 1'b1;
  endtask

  task automatic t_pfail;
    logic [7:0] d; logic oe;
    host_wr(11'h055, 8'h3C);
    pwr_fail = 1'b1;
    host_wr(11'h055, 8'hFF);
    host_rd(11'h055, d, oe);
    chk("R3 no drive under power fail", 64'(oe), 64'd0);
    pwr_fail = 1'b0;
    host_rd(11'h055, d, oe);
    chk("R3 write blocked", 64'(d), 64'h3C);
  endtask

  task automatic t_calib;
    logic [7:0] d; logic oe;
    host_wr(CB + 0, 8'h2A);
    host_rd(CB + 0, d, oe);
    chk("R12 calibration kept", 64'(d), 64'h2A);
    host_wr(CB + 0, 8'h00);
  endtask

  task automatic t_min_hr;
    cal_t t = '{s:58, mi:59, h:10, dw:3, d:15, mo:6, y:23, c:0};
    set_time(t);
    expect_after("R5 minute and hour carry", t, 3);
  endtask

  task automatic t_day;
    cal_t t = '{s:59, mi:59, h:23, dw:7, d:30, mo:4, y:23, c:0};
    set_time(t);
    expect_after("R6 R7 day wrap after 30-day month", t, 1);
  endtask

  task automatic t_long_month;
    cal_t t = '{s:59, mi:59, h:23, dw:2, d:30, mo:7, y:23, c:0};
    set_time(t);
    expect_after("R7 day 31 exists in July", t, 1);
    t = '{s:59, mi:59, h:23, dw:5, d:31, mo:1, y:23, c:1};
    set_time(t);
    expect_after("R7 January end", t, 1);
  endtask

  task automatic t_feb;
    cal_t t = '{s:59, mi:59, h:23, dw:2, d:28, mo:2, y:23, c:0};
    set_time(t);
    expect_after("R8 non-leap February", t, 1);
    t = '{s:59, mi:59, h:23, dw:3, d:28, mo:2, y:24, c:0};
    set_time(t);
    expect_after("R8 leap February 29", t, 1);
    t = '{s:59, mi:59, h:23, dw:4, d:29, mo:2, y:96, c:0};
    set_time(t);
    expect_after("R8 leap February end", t, 1);
  endtask

  task automatic t_year;
    cal_t t = '{s:58, mi:59, h:23, dw:6, d:31, mo:12, y:99, c:0};
    set_time(t);
    expect_after("R9 year and century wrap", t, 2);
  endtask

  task automatic t_freeze;
    cal_t t = '{s:0, mi:0, h:12, dw:1, d:10, mo:3, y:24, c:0};
    logic [7:0] d; logic oe;
    set_time(t);
    expect_after("R10 running before freeze", t, 1);
    host_wr(CB + 0, 8'h40);
    p0 = p0; // commit edge reused only for the unfreeze window below
    wait_until(0);
    begin
      int base = p0;
      while (cyc - base < 3 * TPS) @(negedge clk);
    end
    host_rd(CB + 1, d, oe);
    chk("R10 seconds held while frozen", 64'(d), 64'h01);
  endtask

  task automatic t_freeze_resume;
    cal_t t = '{s:0, mi:0, h:12, dw:1, d:10, mo:3, y:24, c:0};
    logic [7:0] d; logic oe;
    int load_at;
    set_time(t);
    load_at = p0;
    wait_until(TPS + TPS / 2);
    host_wr(CB + 0, 8'h40);
    p0 = load_at;
    wait_until(4 * TPS + TPS / 2);
    host_rd(CB + 1, d, oe);
    chk("R10 frozen snapshot", 64'(d), 64'h01);
    host_wr(CB + 0, 8'h00);
    p0 = load_at;
    expect_after("R10 true time after release", t, 5);
  endtask

  task automatic t_setmode;
    cal_t t = '{s:0, mi:30, h:8, dw:4, d:5, mo:11, y:25, c:0};
    logic [7:0] d; logic oe;
    int base;
    set_time(t);
    host_wr(CB + 0, 8'h80);
    host_wr(CB + 1, 8'h45);
    base = cyc;
    while (cyc - base < 3 * TPS) @(negedge clk);
    host_rd(CB + 1, d, oe);
    chk("R11 copy suppressed in set mode", 64'(d), 64'h45);
    host_wr(CB + 0, 8'h00);
    t.s = 45;
    expect_after("R11 load on clearing set bit", t, 2);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_ram();
    t_pfail();
    t_calib();
    t_min_hr();
    t_day();
    t_long_month();
    t_feb();
    t_year();
    t_freeze();
    t_freeze_resume();
    t_setmode();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errs++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

endmodule